// File: doc/BRIEF.md
# Quadrature Down-Converter with Two-Stage CIC Decimation

This block is the front of one receive channel in a narrowband digital receiver. Each enabled clock carries one real signed ADC sample, together with the cosine and sine samples of a local oscillator that runs at the same rate. Two multipliers produce an in-phase product and a quadrature product. Each product is rounded back to the sample width. The mix moves the wanted carrier to DC.

Each arm then passes through two cascaded cascaded-integrator-comb decimators. Each decimator has four integrator stages and four comb stages. The first decimator reduces the rate by 64 and the second by 8, so one baseband I/Q pair leaves the block for every 512 enabled input samples. Each decimator removes its own gain of R^4 with an arithmetic shift, which gives the block unity gain at DC. Later filtering stages connect directly to the output strobe.

Top module: `qddc_chain`

## Requirements
- R1: During and right after synchronous reset, `bb_vld` is low and `bb_i` and `bb_q` are zero.
- R2: The mixer computes I = round(adc·cos / 2^15) and Q = round(adc·sin / 2^15), where all three inputs are signed two's complement (LO in Q1.15). It rounds halves toward +infinity and saturates a result of +32768 to +32767. Its outputs therefore stay within ±32767.
- R3: The block uses only samples presented with `smp_en` high. Samples with `smp_en` low do not reach the filters and do not advance the decimation count. While `smp_en` stays low, `bb_vld` stays low and `bb_i`/`bb_q` hold.
- R4: `bb_vld` is a one-cycle pulse, issued once per 512 enabled samples. With `smp_en` held high, consecutive pulses are exactly 512 clocks apart. With `smp_en` high every second clock, they are exactly 1024 clocks apart.
- R5: I and Q are produced together. Both arms present their new samples in the same cycle, marked by the single `bb_vld` pulse.
- R6: The DC gain is exactly one. Once the filters have settled on a constant input, every output equals the rounded mixer product bit for bit.
- R7: Integrator registers grow by 4·log2(R) bits (24 bits for the first stage and 12 for the second), so the wraparound of an integrator has no effect on the result. A sustained full-scale input still yields the exact rounded product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_en | input | 1 | Marks a clock that carries a valid sample |
| adc_in | input | 16 | Signed ADC sample |
| lo_cos | input | 16 | Signed LO cosine, Q1.15 |
| lo_sin | input | 16 | Signed LO sine, Q1.15 |
| bb_vld | output | 1 | One-cycle strobe for a new baseband pair |
| bb_i | output | 16 | Decimated in-phase sample |
| bb_q | output | 16 | Decimated quadrature sample |

## Verification
An input sample first appears at the mixer output one clock after it is accepted. The input that completes a 512-sample frame sets `bb_vld` three clocks later: one clock for the mixer register, one for the first decimator's output register and one for the second decimator's output register. The bench drives inputs at the falling edge and samples outputs at the following falling edge, so each registered result is read in the cycle after the edge that produced it. Pulse spacing is measured in clocks between sampled strobes. The filters need several output periods to settle after the input changes. Value checks therefore wait for the tenth strobe after each change, which lies well past the four-stage transient of both decimators.

// File: rtl/qddc_pkg.sv
package qddc_pkg;

    localparam int SAMP_W  = 16;
    localparam int LOSC_W  = 16;
    localparam int STAGES  = 4;
    localparam int DEC_A   = 64;
    localparam int DEC_B   = 8;

    typedef struct packed {
        logic signed [SAMP_W-1:0] i;
        logic signed [SAMP_W-1:0] q;
    } iq_t;

    // bits of growth for an N-stage CIC with unit differential delay
    function automatic int cic_growth(input int rate, input int n);
        return n * $clog2(rate);
    endfunction

endpackage

// File: rtl/qddc_mixer.sv
module qddc_mixer
    import qddc_pkg::*;
#(
    parameter int DW = SAMP_W,
    parameter int LW = LOSC_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic signed [DW-1:0] smp,
    input  logic signed [LW-1:0] cosv,
    input  logic signed [LW-1:0] sinv,
    output logic                 vld,
    output iq_t                  iq
);
    localparam int PW  = DW + LW;
    localparam int FR  = LW - 1;

    function automatic logic signed [DW-1:0] rnd_sat(input logic signed [PW-1:0] p);
        logic signed [PW:0] t;
        logic signed [PW:0] s;
        t = $signed({p[PW-1], p}) + $signed((PW+1)'(1) <<< (FR-1));
        s = t >>> FR;
        if (s > $signed((PW+1)'((1 << (DW-1)) - 1)))
            return DW'((1 << (DW-1)) - 1);
        else
            return s[DW-1:0];
    endfunction

    logic signed [PW-1:0] prod_c;
    logic signed [PW-1:0] prod_s;

    always_comb begin
        prod_c = PW'(smp) * PW'(cosv);
        prod_s = PW'(smp) * PW'(sinv);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld <= 1'b0;
            iq  <= '0;
        end else begin
            vld <= en;
            if (en) begin
                iq.i <= rnd_sat(prod_c);
                iq.q <= rnd_sat(prod_s);
            end
        end
    end
endmodule

// File: rtl/qddc_cic.sv
module qddc_cic #(
    parameter int IN_W  = 16,
    parameter int OUT_W = 16,
    parameter int RATE  = 64,
    parameter int N     = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_vld,
    input  logic signed [IN_W-1:0]  in_dat,
    output logic                    out_vld,
    output logic signed [OUT_W-1:0] out_dat
);
    localparam int SHIFT = N * $clog2(RATE);
    localparam int ACC_W = IN_W + SHIFT;
    localparam int CW    = $clog2(RATE);

    logic signed [ACC_W-1:0] integ [N];
    logic signed [ACC_W-1:0] dly   [N];
    logic signed [ACC_W-1:0] cs    [N+1];
    logic signed [ACC_W-1:0] scaled;
    logic [CW-1:0]           phase;
    logic                    strobe;

    assign strobe = in_vld && (phase == CW'(RATE - 1));

    // integrators at the input rate
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < N; k++) integ[k] <= '0;
            phase <= '0;
        end else if (in_vld) begin
            integ[0] <= integ[0] + ACC_W'(in_dat);
            for (int k = 1; k < N; k++) integ[k] <= integ[k] + integ[k-1];
            phase <= strobe ? '0 : phase + 1'b1;
        end
    end

    // comb chain evaluated at the decimated rate
    always_comb begin
        cs[0] = integ[N-1];
        for (int k = 0; k < N; k++) cs[k+1] = cs[k] - dly[k];
        scaled = cs[N] >>> SHIFT;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < N; k++) dly[k] <= '0;
            out_vld <= 1'b0;
            out_dat <= '0;
        end else begin
            out_vld <= strobe;
            if (strobe) begin
                for (int k = 0; k < N; k++) dly[k] <= cs[k];
                out_dat <= scaled[OUT_W-1:0];
            end
        end
    end
endmodule

// File: rtl/qddc_chain.sv
module qddc_chain
    import qddc_pkg::*;
#(
    parameter int DATA_W = SAMP_W,
    parameter int LO_W   = LOSC_W,
    parameter int NSTG   = STAGES,
    parameter int RATE1  = DEC_A,
    parameter int RATE2  = DEC_B
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     smp_en,
    input  logic signed [DATA_W-1:0] adc_in,
    input  logic signed [LO_W-1:0]   lo_cos,
    input  logic signed [LO_W-1:0]   lo_sin,
    output logic                     bb_vld,
    output logic signed [DATA_W-1:0] bb_i,
    output logic signed [DATA_W-1:0] bb_q
);
    localparam int ARMS = 2;

    iq_t                     mix_iq;
    logic                    mix_vld;
    logic signed [DATA_W-1:0] mix_i;
    logic signed [DATA_W-1:0] mix_q;
    logic signed [DATA_W-1:0] arm_in  [ARMS];
    logic                    mid_vld [ARMS];
    logic signed [DATA_W-1:0] mid_dat [ARMS];
    logic                    arm_vld [ARMS];
    logic signed [DATA_W-1:0] arm_dat [ARMS];

    qddc_mixer #(.DW(DATA_W), .LW(LO_W)) u_mix (
        .clk (clk),
        .rst (rst),
        .en  (smp_en),
        .smp (adc_in),
        .cosv(lo_cos),
        .sinv(lo_sin),
        .vld (mix_vld),
        .iq  (mix_iq)
    );

    assign mix_i     = mix_iq.i;
    assign mix_q     = mix_iq.q;
    assign arm_in[0] = mix_i;
    assign arm_in[1] = mix_q;

    for (genvar a = 0; a < ARMS; a++) begin : g_arm
        qddc_cic #(.IN_W(DATA_W), .OUT_W(DATA_W), .RATE(RATE1), .N(NSTG)) u_cic_a (
            .clk    (clk),
            .rst    (rst),
            .in_vld (mix_vld),
            .in_dat (arm_in[a]),
            .out_vld(mid_vld[a]),
            .out_dat(mid_dat[a])
        );
        qddc_cic #(.IN_W(DATA_W), .OUT_W(DATA_W), .RATE(RATE2), .N(NSTG)) u_cic_b (
            .clk    (clk),
            .rst    (rst),
            .in_vld (mid_vld[a]),
            .in_dat (mid_dat[a]),
            .out_vld(arm_vld[a]),
            .out_dat(arm_dat[a])
        );
    end

    assign bb_vld = arm_vld[0];
    assign bb_i   = arm_dat[0];
    assign bb_q   = arm_dat[1];
endmodule

// File: rtl/qddc_chain_chk.sv
module qddc_chain_chk #(
    parameter int DATA_W = 16
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     smp_en,
    input logic                     mix_vld,
    input logic signed [DATA_W-1:0] mix_i,
    input logic signed [DATA_W-1:0] mix_q,
    input logic                     mid_vld,
    input logic                     vld_i,
    input logic                     vld_q
);
    localparam logic signed [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};

    // R2
    mix_range_chk: assert property (@(posedge clk) disable iff (rst)
        (mix_i != MOST_NEG) && (mix_q != MOST_NEG));

    // R3
    gated_sample_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(smp_en) |-> !mix_vld);

    // R4
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        vld_i |=> !vld_i);

    // R4
    cascade_order_chk: assert property (@(posedge clk) disable iff (rst)
        vld_i |-> $past(mid_vld));

    // R5
    arms_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        vld_i == vld_q);
endmodule

bind qddc_chain qddc_chain_chk #(.DATA_W(DATA_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .smp_en (smp_en),
    .mix_vld(mix_vld),
    .mix_i  (mix_i),
    .mix_q  (mix_q),
    .mid_vld(mid_vld[0]),
    .vld_i  (arm_vld[0]),
    .vld_q  (arm_vld[1])
);

// File: tb/qddc_chain_tb.sv
module qddc_chain_tb;
    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               smp_en = 1'b0;
    logic signed [15:0] adc_in = '0;
    logic signed [15:0] lo_cos = '0;
    logic signed [15:0] lo_sin = '0;
    logic               bb_vld;
    logic signed [15:0] bb_i;
    logic signed [15:0] bb_q;

    int n_run  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always #4 clk = ~clk;

    qddc_chain u_dut (
        .clk(clk), .rst(rst), .smp_en(smp_en),
        .adc_in(adc_in), .lo_cos(lo_cos), .lo_sin(lo_sin),
        .bb_vld(bb_vld), .bb_i(bb_i), .bb_q(bb_q)
    );

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    task automatic check(input string req, input longint act, input longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        cyc++;
        if (cyc > 190000) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            finish_run();
        end
    endtask

    function automatic longint mix_ref(input longint a, input longint b);
        longint r;
        r = (a * b + 16384) >>> 15;
        if (r > 32767) r = 32767;
        return r;
    endfunction

    // apply a constant pattern; duty 1 = every clock, 2 = every second clock
    // junk != 0 puts a different sample on disabled clocks
    task automatic run_pattern(input int a, input int c, input int s,
                               input int duty, input int junk);
        int nv = 0;
        int last = 0;
        int tick = 0;
        longint ei = mix_ref(a, c);
        longint eq = mix_ref(a, s);
        while (nv < 10) begin
            smp_en = (tick % duty) == 0;
            adc_in = (smp_en || junk == 0) ? 16'(a) : 16'(junk);
            lo_cos = 16'(c);
            lo_sin = 16'(s);
            step();
            tick++;
            if (bb_vld) begin
                nv++;
                if (nv > 1) check("R4 spacing", cyc - last, 512 * duty);
                last = cyc;
                if (nv == 10) begin
                    // R6 R7 settled value; R5 both arms at the same strobe
                    check("R6 I value", bb_i, ei);
                    check("R5 Q value", bb_q, eq);
                    if (junk != 0) check("R3 disabled samples ignored", bb_i, ei);
                end
            end
        end
    endtask

    initial begin
        int seen;
        logic signed [15:0] hold_i;
        logic signed [15:0] hold_q;

        rst = 1'b1;
        for (int k = 0; k < 4; k++) step();
        // R1 outputs during reset
        check("R1 vld in reset", bb_vld, 0);
        rst = 1'b0;
        step();
        check("R1 vld after reset", bb_vld, 0);
        check("R1 I after reset", bb_i, 0);
        check("R1 Q after reset", bb_q, 0);

        // R2 R6 several constant patterns
        run_pattern(1000, 16384, -16384, 1, 0);
        run_pattern(-12345, 23170, 23170, 1, 0);
        run_pattern(3, 16384, -16384, 1, 0);      // half rounds up / toward +inf
        run_pattern(0, 32767, 32767, 1, 0);
        // R2 saturation of +32768; R7 full-scale sustained input
        run_pattern(-32768, -32768, 32767, 1, 0);
        run_pattern(32767, 32767, -32768, 1, 0);
        // R3 R4 gapped enable with junk on disabled clocks
        run_pattern(7777, -20000, 12000, 2, -31000);
        run_pattern(-500, 30000, -30000, 2, 29999);

        // R3 enable held low: no strobe, outputs hold
        hold_i = bb_i;
        hold_q = bb_q;
        seen = 0;
        smp_en = 1'b0;
        for (int k = 0; k < 3000; k++) begin
            adc_in = 16'(k * 37);
            step();
            if (bb_vld) seen++;
        end
        check("R3 no strobe while disabled", seen, 0);
        check("R3 I held", bb_i, hold_i);
        check("R3 Q held", bb_q, hold_q);

        finish_run();
    end
endmodule